// File: doc/BRIEF.md
# Paletted Text Pixel Decoder

This block turns one text or tile cell into a stream of 8-bit global palette indices. For each cell it takes the character code, the font byte fetched for the current scanline, a colour depth of 1 to 4 bits per pixel, a multicolour flag, a double-width flag and eight shared colour registers. It returns, without a clock, the glyph number that addresses font memory. After a cell is loaded it puts out one pixel colour per clock.

Colour depths above one bit per pixel take the upper bits of the character code as palette bank bits, so fewer glyphs remain. At 4 bits per pixel the top code bit is a per-cell half-bright flag. It flips bit 2 of every looked-up colour in the cell, which selects the other brightness level of the same hue. Multicolour reads two font bits per pixel, so a cell is 4 pixels wide. Double width shows each pixel for two clocks.

A new cell is accepted when the block is idle, and also on the clock that shows the last pixel of the current cell. This lets cells follow each other with no gap.

Top module: `pal_text_decoder`

## Requirements
- R1: While reset is asserted and after its release, `pix_valid` is 0, `pix_color` is 0 and `load_ready` is 1 until a cell is loaded.
- R2: `glyph_idx` is the character code with its stolen high bits cleared. The low 8, 7, 6 or 5 bits are kept for depth codes `bpp_sel` = 0, 1, 2, 3 (1, 2, 3, 4 bpp) without multicolour. With multicolour the low 8, 7 or 6 bits are kept for `bpp_sel` = 1, 2, 3.
- R3: At 1 bpp each font bit selects shared colour 0 (bit clear) or shared colour 1 (bit set). All code bits are glyph bits.
- R4: At 2 bpp without multicolour the palette index is {0, code[7], font bit}.
- R5: At 3 bpp without multicolour the palette index is {code[7], code[6], font bit}.
- R6: At 4 bpp the palette index is {code[6], code[5], font bit}, or {code[6], font pair} with multicolour. When code[7] is 1, bit 2 of every looked-up colour in the cell is inverted.
- R7: With multicolour, each pixel takes two font bits as palette index bits 1..0 and a cell has 4 pixels. At 2 bpp the index is {0, pair}; at 3 bpp it is {code[7], pair}.
- R8: Multicolour requested at 1 bpp is decoded exactly as 1 bpp without multicolour: 8 pixels per cell and all 8 glyph bits kept.
- R9: With double width, each pixel is shown on two consecutive clocks, so a cell lasts 16 clocks (8 with multicolour).
- R10: Pixels come from the font byte most significant bit first, or most significant pair first in multicolour.
- R11: A load accepted with `cell_load` at a clock edge makes its first pixel valid on the next cycle. A load on the cycle that shows a cell's last pixel starts the next cell with no gap. A load on any other busy cycle is ignored.
- R12: `pix_valid` stays high for exactly the cell length and then falls unless a new cell was taken on the last pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_load | input | 1 | Load request for the cell on the inputs below |
| char_code | input | 8 | Character code byte of the cell |
| font_byte | input | 8 | Font byte for the current scanline |
| bpp_sel | input | 2 | Colour depth code: 0 to 3 mean 1 to 4 bpp |
| multi | input | 1 | Multicolour flag |
| dbl | input | 1 | Double-width flag |
| shared_colors | input | 64 | Eight 8-bit colours; entry i in bits 8i+7..8i |
| glyph_idx | output | 8 | Glyph number for font addressing (from the current inputs) |
| load_ready | output | 1 | A load on this cycle is accepted |
| pix_valid | output | 1 | `pix_color` carries a pixel |
| pix_color | output | 8 | Global palette index of the current pixel |

## Verification
The function that can fall in the same cycle as another is the load of a new cell, which can coincide with the display of the previous cell's last pixel. The bench raises `cell_load` during the final pixel of a cell. It requires that the last pixel still shows the old cell's colour and that the next cycle shows the new cell's first pixel with no idle cycle between them. The bench also raises `cell_load` in the middle of a cell and requires that the running stream continues unchanged and then ends on time.

// File: rtl/pal_text_decoder.sv
module pal_text_decoder #(
  parameter int COLOR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cell_load,
  input  logic [7:0]           char_code,
  input  logic [7:0]           font_byte,
  input  logic [1:0]           bpp_sel,
  input  logic                 multi,
  input  logic                 dbl,
  input  logic [8*COLOR_W-1:0] shared_colors,
  output logic [7:0]           glyph_idx,
  output logic                 load_ready,
  output logic                 pix_valid,
  output logic [COLOR_W-1:0]   pix_color
);

  localparam int CNT_W = 4;

  logic             busy, mc_q, dbl_q, hb_q;
  logic [1:0]       hi_q;
  logic [7:0]       font_q;
  logic [CNT_W-1:0] cnt, len_q;
  logic             last, take, emc;
  logic [1:0]       hi_d;
  logic [2:0]       pos, pal_idx;
  logic [7:0]       sh;

  assign emc = multi && (bpp_sel != 2'd0);

  always_comb begin
    glyph_idx = char_code;
    hi_d = 2'b00;
    if (emc) begin
      case (bpp_sel)
        2'd2:    begin glyph_idx[7] = 1'b0; hi_d = {1'b0, char_code[7]}; end
        2'd3:    begin glyph_idx[7:6] = 2'b00; hi_d = {1'b0, char_code[6]}; end
        default: ;
      endcase
    end else begin
      case (bpp_sel)
        2'd1: begin glyph_idx[7] = 1'b0; hi_d = {1'b0, char_code[7]}; end
        2'd2: begin glyph_idx[7:6] = 2'b00; hi_d = char_code[7:6]; end
        2'd3: begin glyph_idx[7:5] = 3'b000; hi_d = char_code[6:5]; end
        default: ;
      endcase
    end
  end

  assign last       = busy && (cnt == len_q - 1'b1);
  assign load_ready = !busy || last;
  assign take       = cell_load && load_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      font_q <= '0;
      hi_q   <= '0;
      mc_q   <= 1'b0;
      dbl_q  <= 1'b0;
      hb_q   <= 1'b0;
    end else if (take) begin
      busy   <= 1'b1;
      cnt    <= '0;
      len_q  <= (emc ? CNT_W'(4) : CNT_W'(8)) << dbl;
      font_q <= font_byte;
      hi_q   <= hi_d;
      mc_q   <= emc;
      dbl_q  <= dbl;
      hb_q   <= (bpp_sel == 2'd3) && char_code[7];
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign pos     = dbl_q ? cnt[3:1] : cnt[2:0];
  assign sh      = mc_q ? (font_q << {pos[1:0], 1'b0}) : (font_q << pos);
  assign pal_idx = mc_q ? {hi_q[0], sh[7:6]} : {hi_q, sh[7]};

  assign pix_valid = busy;
  assign pix_color = busy ? (shared_colors[pal_idx*COLOR_W +: COLOR_W] ^ (COLOR_W'(hb_q) << 2))
                          : '0;

endmodule

module pal_text_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cell_load,
  input logic       load_ready,
  input logic       pix_valid,
  input logic [7:0] pix_color,
  input logic [7:0] char_code,
  input logic [7:0] glyph_idx,
  input logic       dbl_q,
  input logic [3:0] cnt
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !pix_valid && pix_color == 8'h00);

  // R2
  glyph_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glyph_idx & ~char_code) == 8'h00);

  // R11
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_load && load_ready |=> pix_valid);

  // R12
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !load_ready |=> pix_valid);

  // R9
  wide_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && dbl_q && !cnt[0] |=> pix_valid && pix_color == $past(pix_color));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix_color == 8'h00);

endmodule

bind pal_text_decoder pal_text_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cell_load(cell_load), .load_ready(load_ready),
  .pix_valid(pix_valid), .pix_color(pix_color), .char_code(char_code),
  .glyph_idx(glyph_idx), .dbl_q(dbl_q), .cnt(cnt)
);

// File: tb/pal_text_decoder_test.sv
module pal_text_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cell_load = 1'b0;
  logic [7:0]  char_code = 8'h00, font_byte = 8'h00;
  logic [1:0]  bpp_sel = 2'd0;
  logic        multi = 1'b0, dbl = 1'b0;
  logic [63:0] shared_colors;
  logic [7:0]  glyph_idx, pix_color;
  logic        load_ready, pix_valid;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pal_text_decoder uut (.*);

  function automatic logic [7:0] col(input int i);
    return 8'(8'h41 + 8'h25 * i);
  endfunction

  initial for (int i = 0; i < 8; i++) shared_colors[8*i +: 8] = col(i);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cell_len(input logic [1:0] b, input logic m, input logic d);
    int w;
    w = (m && b != 0) ? 4 : 8;
    return d ? 2 * w : w;
  endfunction

  function automatic logic [7:0] exp_pix(input logic [7:0] c, input logic [7:0] f,
      input logic [1:0] b, input logic m, input logic d, input int k);
    int p, idx;
    logic [7:0] v;
    p = d ? k / 2 : k;
    if (m && b != 0) begin
      idx = (f >> (6 - 2 * p)) & 3;
      if (b == 2) idx += c[7] ? 4 : 0;
      if (b == 3) idx += c[6] ? 4 : 0;
    end else begin
      idx = f[7 - p];
      if (b == 1) idx += c[7] ? 2 : 0;
      if (b == 2) idx += (c[7] ? 4 : 0) + (c[6] ? 2 : 0);
      if (b == 3) idx += (c[6] ? 4 : 0) + (c[5] ? 2 : 0);
    end
    v = col(idx);
    if (b == 3 && c[7]) v[2] = ~v[2];
    return v;
  endfunction

  function automatic logic [7:0] exp_glyph(input logic [7:0] c, input logic [1:0] b, input logic m);
    int keep;
    if (m && b != 0) keep = (b == 1) ? 8 : (b == 2) ? 7 : 6;
    else keep = 8 - b;
    return c & 8'((1 << keep) - 1);
  endfunction

  task automatic drive(input logic [7:0] c, input logic [7:0] f, input logic [1:0] b,
      input logic m, input logic d);
    char_code = c; font_byte = f; bpp_sel = b; multi = m; dbl = d;
  endtask

  task automatic run_cell(input string req, input logic [7:0] c, input logic [7:0] f,
      input logic [1:0] b, input logic m, input logic d);
    int n;
    @(negedge clk);
    drive(c, f, b, m, d);
    #0.5;
    check({req, " R2 glyph"}, glyph_idx, exp_glyph(c, b, m));
    cell_load = 1'b1;
    @(negedge clk);
    cell_load = 1'b0;
    n = cell_len(b, m, d);
    for (int k = 0; k < n; k++) begin
      check({req, " R12 valid"}, pix_valid, 1'b1);
      check({req, " R10 pixel"}, pix_color, exp_pix(c, f, b, m, d, k));
      @(negedge clk);
    end
    check({req, " R12 end"}, pix_valid, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 valid", pix_valid, 1'b0);
    check("R1 color", pix_color, 8'h00);
    check("R1 ready", load_ready, 1'b1);
  endtask

  task automatic t_modes();
    run_cell("R3 1bpp", 8'hD7, 8'b1011_0010, 2'd0, 1'b0, 1'b0);
    run_cell("R4 2bpp hi", 8'h9A, 8'b0110_1001, 2'd1, 1'b0, 1'b0);
    run_cell("R4 2bpp lo", 8'h1A, 8'b1100_0011, 2'd1, 1'b0, 1'b0);
    run_cell("R5 3bpp", 8'h7F, 8'b1010_0101, 2'd2, 1'b0, 1'b0);
    run_cell("R5 3bpp b", 8'hBF, 8'b0001_1110, 2'd2, 1'b0, 1'b0);
    run_cell("R6 4bpp hb", 8'hC3, 8'b1110_0001, 2'd3, 1'b0, 1'b0);
    run_cell("R6 4bpp nohb", 8'h43, 8'b1110_0001, 2'd3, 1'b0, 1'b0);
    run_cell("R7 multi2", 8'hFF, 8'b0001_1011, 2'd1, 1'b1, 1'b0);
    run_cell("R7 multi3", 8'hA5, 8'b1110_0100, 2'd2, 1'b1, 1'b0);
    run_cell("R6 multi4 hb", 8'hC9, 8'b0110_1100, 2'd3, 1'b1, 1'b0);
    run_cell("R8 multi1", 8'hE4, 8'b1001_0110, 2'd0, 1'b1, 1'b0);
    run_cell("R9 wide", 8'h85, 8'b1100_1010, 2'd1, 1'b0, 1'b1);
    run_cell("R9 wide multi", 8'h40, 8'b1001_1100, 2'd3, 1'b1, 1'b1);
  endtask

  task automatic t_back_to_back();
    int n;
    @(negedge clk);
    drive(8'h80, 8'b1010_1010, 2'd1, 1'b0, 1'b0);
    cell_load = 1'b1;
    @(negedge clk);
    cell_load = 1'b0;
    n = 8;
    for (int k = 0; k < n; k++) begin
      check("R10 first cell", pix_color, exp_pix(8'h80, 8'b1010_1010, 2'd1, 1'b0, 1'b0, k));
      if (k == n - 1) begin
        check("R11 ready on last", load_ready, 1'b1);
        drive(8'h20, 8'b0011_0011, 2'd2, 1'b1, 1'b0);
        cell_load = 1'b1;
      end
      @(negedge clk);
    end
    cell_load = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R11 chained valid", pix_valid, 1'b1);
      check("R11 chained pixel", pix_color, exp_pix(8'h20, 8'b0011_0011, 2'd2, 1'b1, 1'b0, k));
      @(negedge clk);
    end
    check("R12 chained end", pix_valid, 1'b0);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    drive(8'h3C, 8'b1111_0000, 2'd0, 1'b0, 1'b0);
    cell_load = 1'b1;
    @(negedge clk);
    cell_load = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check("R11 busy stream", pix_color, exp_pix(8'h3C, 8'b1111_0000, 2'd0, 1'b0, 1'b0, k));
      if (k == 2) begin
        check("R11 not ready", load_ready, 1'b0);
        drive(8'hFF, 8'b0000_1111, 2'd3, 1'b1, 1'b1);
        cell_load = 1'b1;
      end else cell_load = 1'b0;
      @(negedge clk);
    end
    check("R11 ignored load", pix_valid, 1'b0);
  endtask

  initial begin
    #1;
    t_reset();
    #10;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_back_to_back();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule